// File: doc/BRIEF.md
# Multi-cycle result interlock controller

This block decides, every cycle, whether the main pipeline of an in-order, single-issue integer core may advance. It watches the instruction sitting in decode: two source register tags, a destination tag and an operation class. It keeps track of results still being computed by four long-latency units: integer multiply/divide, FP add, FP multiply and FP divide. It also tracks loads whose data is not yet back, and data-cache misses. Whenever any hazard holds, it raises a single `freeze` that stalls the whole main pipeline. No later instruction slips past a stalled one.

The decode side is a valid/ready stream in which `freeze` acts as the inverted ready. An instruction is taken in a cycle where `id_valid` is high and `freeze` is low. While `freeze` is high the decoder must hold the same instruction on its inputs. `freeze` can also rise with `id_valid` low, while a cache refill is outstanding. The miss and refill-done pins are plain control inputs.

Hardware does not check the first delay cycle after a load, and it does not check the slot after a branch. Scheduled code fills those slots. Load delay cycles beyond the first, and every long-unit result, are interlocked. All unit latencies are parameters and must each be at least 2.

Top module: `result_interlock`

## Requirements
- R1: A synchronous active-high `rst` clears every pending register, every unit countdown, all load tracking and the miss hold. In the first cycle after reset, an instruction that reads a register whose producer was cut off by the reset issues without freeze. So does a new operation sent to a unit that reset cut off.
- R2: Operation codes on `id_op` are 0 ALU, 1 load, 2 branch, 3 integer multiply, 4 integer divide, 5 FP add, 6 FP multiply and 7 FP divide. A valid instruction whose source A or source B names a register awaiting a result from codes 3 to 7 raises `freeze`.
- R3: Take a long-unit operation of latency L issued in cycle t. An instruction that reads its destination is frozen in cycles t+1 to t+L-1 and issues in cycle t+L, the cycle in which the unit's countdown reaches zero.
- R4: Register tag 0 is never pending. Reading it, or writing it from a long unit, never causes a data-hazard freeze.
- R5: A long-unit operation aimed at a unit still counting down raises `freeze` until the cycle its count reaches zero. Integer multiply and integer divide share one unit.
- R6: A valid instruction whose destination is still awaiting a long-unit result raises `freeze` until that result is ready.
- R7: The instruction in decode in the cycle right after a load issues never freezes on the load's destination and reads the old value.
- R8: Count a load's age in cycles starting at 1 in the cycle after its issue. A reader of the load's destination freezes while the load is aged 2 to LOAD_LAT. Load ageing is suspended in cycles where the miss hold is active.
- R9: A branch creates no pending result. The instruction after a branch issues without a freeze caused by the branch.
- R10: `dc_miss` raises `freeze` in its own cycle. The freeze persists without further `dc_miss` until the cycle where `dc_refill_done` is high, when it drops. A miss and refill-done in the same cycle cause no freeze. Long-unit countdowns keep running during the hold.
- R11: An instruction is taken only in a cycle with `id_valid` high and `freeze` low. An instruction held under `freeze` is taken later, and its latency counts from the cycle in which it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | An instruction is present in decode |
| id_op | input | 3 | Operation class (encoding in R2) |
| id_src_a | input | TAG_W | First source register tag |
| id_src_b | input | TAG_W | Second source register tag |
| id_dst | input | TAG_W | Destination register tag (0 for none) |
| dc_miss | input | 1 | Data cache reports a miss this cycle |
| dc_refill_done | input | 1 | Outstanding refill completes this cycle |
| freeze | output | 1 | Stall the entire main pipeline; inverted ready for decode |

## Verification
On every cycle, the embedded properties check the following. A unit only starts from a zero count, and it then counts down by one each cycle. A released unit is idle in the next cycle. A register is never marked pending twice. Load ages stay frozen while the miss hold is active. A miss without refill-done keeps the pipeline frozen one cycle later. The exact stall lengths come only from the bench scenarios: the latency-to-issue windows, the unfilled load slot against the second load cycle, the shared multiply/divide unit, write-after-write waits, and a frozen instruction issuing late. So do the interplay of a miss with running countdowns and with load ageing, and the way reset cuts off work in flight.

// File: rtl/rilk_pkg.sv
package rilk_pkg;

  typedef enum logic [2:0] {
    OP_ALU    = 3'd0,
    OP_LOAD   = 3'd1,
    OP_BRANCH = 3'd2,
    OP_IMUL   = 3'd3,
    OP_IDIV   = 3'd4,
    OP_FADD   = 3'd5,
    OP_FMUL   = 3'd6,
    OP_FDIV   = 3'd7
  } op_e;

  localparam int NUM_UNITS = 4;
  localparam int UNIT_W    = 2;

  function automatic logic is_long(op_e op);
    return (op == OP_IMUL) || (op == OP_IDIV) || (op == OP_FADD) ||
           (op == OP_FMUL) || (op == OP_FDIV);
  endfunction

  // multiply and divide share unit 0
  function automatic logic [UNIT_W-1:0] unit_of(op_e op);
    case (op)
      OP_FADD: return 2'd1;
      OP_FMUL: return 2'd2;
      OP_FDIV: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rilk_unit.sv
module rilk_unit #(
  parameter int CNT_W = 6,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] lat_m1,
  input  logic [TAG_W-1:0] start_tag,
  output logic             busy,
  output logic             rel,
  output logic [TAG_W-1:0] rel_tag
);

  logic [CNT_W-1:0] cnt;
  logic [TAG_W-1:0] tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tag <= '0;
    end else if (start) begin
      cnt <= lat_m1;
      tag <= start_tag;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign busy    = (cnt != '0);
  assign rel     = (cnt == CNT_W'(1));
  assign rel_tag = tag;

  p_start_free_r5: assert property (@(posedge clk) disable iff (rst)
    start |-> (cnt == '0))
    else $error("unit started while counting");

  p_countdown_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)))
    else $error("unit countdown skipped");

  p_release_idle_r3: assert property (@(posedge clk) disable iff (rst)
    rel |=> !busy)
    else $error("unit busy after release");

endmodule

// File: rtl/rilk_regboard.sv
module rilk_regboard #(
  parameter int TAG_W     = 6,
  parameter int NUM_UNITS = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            set_en,
  input  logic [TAG_W-1:0]                set_tag,
  input  logic [NUM_UNITS-1:0]            rel_vec,
  input  logic [NUM_UNITS-1:0][TAG_W-1:0] rel_tags,
  input  logic [TAG_W-1:0]                src_a,
  input  logic [TAG_W-1:0]                src_b,
  input  logic [TAG_W-1:0]                dst,
  output logic                            hit_a,
  output logic                            hit_b,
  output logic                            hit_d
);

  localparam int NUM_REGS = 1 << TAG_W;

  logic [NUM_REGS-1:0] pend;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign pend[i] = 1'b0;
    end else begin : g_live
      logic p;
      logic clr;
      always_comb begin
        clr = 1'b0;
        for (int u = 0; u < NUM_UNITS; u++) begin
          if (rel_vec[u] && (rel_tags[u] == TAG_W'(i))) clr = 1'b1;
        end
      end
      always_ff @(posedge clk) begin
        if (rst)                                   p <= 1'b0;
        else if (set_en && (set_tag == TAG_W'(i))) p <= 1'b1;
        else if (clr)                              p <= 1'b0;
      end
      assign pend[i] = p;
    end
  end

  assign hit_a = pend[src_a];
  assign hit_b = pend[src_b];
  assign hit_d = pend[dst];

  p_set_fresh_r6: assert property (@(posedge clk) disable iff (rst)
    (set_en && (set_tag != '0)) |-> !pend[set_tag])
    else $error("register marked pending twice");

endmodule

// File: rtl/rilk_ldpipe.sv
module rilk_ldpipe #(
  parameter int TAG_W = 6,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [TAG_W-1:0] src_a,
  input  logic [TAG_W-1:0] src_b,
  output logic             hit
);

  // index k holds the load of age k+1
  logic [DEPTH-1:0]            v;
  logic [DEPTH-1:0][TAG_W-1:0] t;

  always_ff @(posedge clk) begin
    if (rst) begin
      v <= '0;
      t <= '0;
    end else if (!hold) begin
      v[0] <= push;
      t[0] <= push_tag;
      for (int k = 1; k < DEPTH; k++) begin
        v[k] <= v[k-1];
        t[k] <= t[k-1];
      end
    end
  end

  // age 1 is the unchecked slot; ages 2..DEPTH interlock
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((k > 0) && v[k] && ((t[k] == src_a) || (t[k] == src_b))) hit = 1'b1;
    end
  end

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    hold |=> (v == $past(v)))
    else $error("load ages moved during miss hold");

endmodule

// File: rtl/result_interlock.sv
module result_interlock #(
  parameter int TAG_W    = 6,
  parameter int LAT_IMUL = 6,
  parameter int LAT_IDIV = 35,
  parameter int LAT_FADD = 2,
  parameter int LAT_FMUL = 5,
  parameter int LAT_FDIV = 19,
  parameter int LOAD_LAT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_valid,
  input  logic [2:0]       id_op,
  input  logic [TAG_W-1:0] id_src_a,
  input  logic [TAG_W-1:0] id_src_b,
  input  logic [TAG_W-1:0] id_dst,
  input  logic             dc_miss,
  input  logic             dc_refill_done,
  output logic             freeze
);
  import rilk_pkg::*;

  localparam int MAX_LAT = max2(max2(max2(LAT_IMUL, LAT_IDIV), max2(LAT_FADD, LAT_FMUL)), LAT_FDIV);
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  op_e               op;
  logic              long_op;
  logic [UNIT_W-1:0] unit_sel;
  logic [CNT_W-1:0]  lat_m1;

  assign op       = op_e'(id_op);
  assign long_op  = is_long(op);
  assign unit_sel = unit_of(op);

  always_comb begin
    case (op)
      OP_IMUL: lat_m1 = CNT_W'(LAT_IMUL - 1);
      OP_IDIV: lat_m1 = CNT_W'(LAT_IDIV - 1);
      OP_FADD: lat_m1 = CNT_W'(LAT_FADD - 1);
      OP_FMUL: lat_m1 = CNT_W'(LAT_FMUL - 1);
      OP_FDIV: lat_m1 = CNT_W'(LAT_FDIV - 1);
      default: lat_m1 = '0;
    endcase
  end

  // miss hold
  logic miss_q;
  logic miss_frz;

  assign miss_frz = (dc_miss | miss_q) & ~dc_refill_done;

  always_ff @(posedge clk) begin
    if (rst) miss_q <= 1'b0;
    else     miss_q <= miss_frz;
  end

  // hazards
  logic                            issue;
  logic                            hit_a, hit_b, hit_d, ld_hit;
  logic                            hazard;
  logic [NUM_UNITS-1:0]            start_vec, busy_vec, rel_vec;
  logic [NUM_UNITS-1:0][TAG_W-1:0] rel_tags;

  assign hazard = id_valid & (hit_a | hit_b | hit_d | ld_hit |
                              (long_op & busy_vec[unit_sel]));
  assign freeze = miss_frz | hazard;
  assign issue  = id_valid & ~freeze;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign start_vec[u] = issue & long_op & (unit_sel == UNIT_W'(u));
    rilk_unit #(
      .CNT_W (CNT_W),
      .TAG_W (TAG_W)
    ) u_trk (
      .clk       (clk),
      .rst       (rst),
      .start     (start_vec[u]),
      .lat_m1    (lat_m1),
      .start_tag (id_dst),
      .busy      (busy_vec[u]),
      .rel       (rel_vec[u]),
      .rel_tag   (rel_tags[u])
    );
  end

  rilk_regboard #(
    .TAG_W     (TAG_W),
    .NUM_UNITS (NUM_UNITS)
  ) u_board (
    .clk      (clk),
    .rst      (rst),
    .set_en   (issue & long_op),
    .set_tag  (id_dst),
    .rel_vec  (rel_vec),
    .rel_tags (rel_tags),
    .src_a    (id_src_a),
    .src_b    (id_src_b),
    .dst      (id_dst),
    .hit_a    (hit_a),
    .hit_b    (hit_b),
    .hit_d    (hit_d)
  );

  rilk_ldpipe #(
    .TAG_W (TAG_W),
    .DEPTH (LOAD_LAT)
  ) u_ld (
    .clk      (clk),
    .rst      (rst),
    .hold     (miss_frz),
    .push     (issue & (op == OP_LOAD) & (id_dst != '0)),
    .push_tag (id_dst),
    .src_a    (id_src_a),
    .src_b    (id_src_b),
    .hit      (ld_hit)
  );

  p_miss_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (dc_miss && !dc_refill_done) |=> (freeze || dc_refill_done))
    else $error("miss hold dropped early");

endmodule

// File: tb/result_interlock_test.sv
`timescale 1ns/1ps
module result_interlock_test;

  localparam int TW = 6;
  localparam logic [2:0] ALU = 3'd0, LD = 3'd1, BR = 3'd2, IMUL = 3'd3,
                         IDIV = 3'd4, FADD = 3'd5, FMUL = 3'd6, FDIV = 3'd7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          id_valid = 1'b0;
  logic [2:0]    id_op = 3'd0;
  logic [TW-1:0] id_src_a = '0, id_src_b = '0, id_dst = '0;
  logic          dc_miss = 1'b0, dc_refill_done = 1'b0;
  logic          freeze;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  bit    exp_q[$];
  string tag_q[$];
  bit    e_cur;
  string t_cur;

  always #4 clk = ~clk;

  result_interlock #(
    .TAG_W(TW), .LAT_IMUL(4), .LAT_IDIV(8), .LAT_FADD(2),
    .LAT_FMUL(5), .LAT_FDIV(6), .LOAD_LAT(2)
  ) uut (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_op(id_op),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_dst(id_dst),
    .dc_miss(dc_miss), .dc_refill_done(dc_refill_done), .freeze(freeze)
  );

  // monitor: compares at mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      e_cur = exp_q.pop_front();
      t_cur = tag_q.pop_front();
      checks++;
      if (freeze !== e_cur) begin
        bad++;
        $display("FAIL %s: freeze=%0b expected=%0b", t_cur, freeze, e_cur);
      end
    end
  end

  // driver: one cycle per call
  task automatic step(input logic v, input logic [2:0] op,
                      input logic [TW-1:0] a, input logic [TW-1:0] b,
                      input logic [TW-1:0] d, input logic miss,
                      input logic rd, input bit exp, input string tag);
    @(posedge clk); #2;
    id_valid = v; id_op = op; id_src_a = a; id_src_b = b; id_dst = d;
    dc_miss = miss; dc_refill_done = rd;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, ALU, 0, 0, 0, 0, 0, 0, "R11 idle");
  endtask

  task automatic pulse_reset();
    @(posedge clk); #2;
    rst = 1'b1; id_valid = 1'b0; dc_miss = 1'b0; dc_refill_done = 1'b0;
    @(posedge clk); #2;
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    step(1, ALU, 5, 6, 7, 0, 0, 0, "R1 reset state");

    // FP add, latency 2, source A
    step(1, FADD, 33, 34, 40, 0, 0, 0, "R2 fadd issue");
    step(1, ALU, 40, 1, 2, 0, 0, 1, "R2 read pending A");
    step(1, ALU, 40, 1, 2, 0, 0, 0, "R3 fadd release at L");

    // FP multiply, latency 5, source B
    step(1, FMUL, 33, 34, 41, 0, 0, 0, "R3 fmul issue");
    for (int i = 0; i < 4; i++) step(1, ALU, 1, 41, 3, 0, 0, 1, "R2 read pending B");
    step(1, ALU, 1, 41, 3, 0, 0, 0, "R3 fmul release at L");

    // register 0 and busy unit
    step(1, FMUL, 33, 34, 0, 0, 0, 0, "R4 fmul to r0");
    step(1, ALU, 0, 0, 4, 0, 0, 0, "R4 r0 never pending");
    for (int i = 0; i < 3; i++) step(1, FMUL, 33, 34, 42, 0, 0, 1, "R5 fmul busy");
    step(1, FMUL, 33, 34, 42, 0, 0, 0, "R5 fmul free");
    idle(4);

    // shared multiply/divide unit
    step(1, IMUL, 1, 2, 10, 0, 0, 0, "R5 imul issue");
    for (int i = 0; i < 3; i++) step(1, IDIV, 1, 2, 11, 0, 0, 1, "R5 idiv waits imul");
    step(1, IDIV, 1, 2, 11, 0, 0, 0, "R11 idiv taken late");
    for (int i = 0; i < 7; i++) step(1, ALU, 11, 0, 5, 0, 0, 1, "R11 idiv latency from take");
    step(1, ALU, 11, 0, 5, 0, 0, 0, "R3 idiv release");

    // write after write
    step(1, FDIV, 33, 34, 45, 0, 0, 0, "R6 fdiv issue");
    for (int i = 0; i < 5; i++) step(1, ALU, 1, 2, 45, 0, 0, 1, "R6 dst pending");
    step(1, ALU, 1, 2, 45, 0, 0, 0, "R6 dst free");

    // loads with LOAD_LAT 2
    step(1, LD, 1, 0, 12, 0, 0, 0, "R7 load issue");
    step(1, ALU, 12, 0, 6, 0, 0, 0, "R7 unchecked slot");
    step(1, ALU, 12, 0, 6, 0, 0, 1, "R8 age 2 stall");
    step(1, ALU, 12, 0, 6, 0, 0, 0, "R8 after load");
    step(1, LD, 1, 0, 13, 0, 0, 0, "R8 load issue");
    step(1, ALU, 5, 7, 8, 0, 0, 0, "R8 independent");
    step(1, ALU, 3, 13, 8, 0, 0, 1, "R8 age 2 via B");
    step(1, ALU, 3, 13, 8, 0, 0, 0, "R8 done");

    // branch
    step(1, LD, 1, 0, 14, 0, 0, 0, "R9 load");
    step(1, BR, 14, 2, 0, 0, 0, 0, "R9 branch in load slot");
    step(1, ALU, 14, 9, 9, 0, 0, 1, "R8 load age 2 after branch");
    step(1, ALU, 9, 9, 9, 0, 0, 0, "R9 after branch");

    // miss hold, frozen instruction taken later
    step(0, ALU, 0, 0, 0, 1, 0, 1, "R10 miss");
    step(1, FADD, 33, 34, 46, 0, 0, 1, "R10 hold");
    step(1, FADD, 33, 34, 46, 0, 0, 1, "R10 hold");
    step(1, FADD, 33, 34, 46, 0, 1, 0, "R10 refill release");
    step(1, ALU, 46, 0, 2, 0, 0, 1, "R11 fadd taken at refill");
    step(1, ALU, 46, 0, 2, 0, 0, 0, "R3 fadd release");

    // countdown continues under miss
    step(1, FDIV, 33, 34, 50, 0, 0, 0, "R10 fdiv issue");
    step(0, ALU, 0, 0, 0, 1, 0, 1, "R10 miss");
    for (int i = 0; i < 4; i++) step(0, ALU, 0, 0, 0, 0, 0, 1, "R10 hold");
    step(1, ALU, 50, 0, 2, 0, 1, 0, "R10 unit ran during hold");

    // same-cycle miss and refill
    step(1, ALU, 1, 2, 3, 1, 1, 0, "R10 zero-wait refill");
    step(1, ALU, 1, 2, 3, 0, 0, 0, "R10 no residue");

    // load ageing paused by miss
    step(1, LD, 1, 0, 15, 0, 0, 0, "R8 load issue");
    step(0, ALU, 0, 0, 0, 1, 0, 1, "R8 miss");
    step(1, ALU, 15, 0, 2, 0, 1, 0, "R8 still age 1");
    step(1, ALU, 15, 0, 2, 0, 0, 1, "R8 age 2 after hold");
    step(1, ALU, 15, 0, 2, 0, 0, 0, "R8 done");

    // reset cuts off work in flight
    step(1, FDIV, 33, 34, 47, 0, 0, 0, "R1 fdiv issue");
    pulse_reset();
    step(1, ALU, 47, 0, 2, 0, 0, 0, "R1 pending cleared");
    step(1, FDIV, 33, 34, 48, 0, 0, 0, "R1 unit cleared");
    step(1, ALU, 48, 0, 2, 0, 0, 1, "R2 fresh fdiv pending");
    idle(2);

    @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      bad++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule